// File: doc/BRIEF.md
# Reset Strap and Parity Pin Sharer

This block owns three shared chip pins that serve two purposes at different times. While hardware reset is active, and for the cycle that ends it, the pins are inputs. Their levels pass through a short synchronizer and are latched once, on the first clock edge after reset is released. The three latched levels become configuration outputs: a CPU-off strap, a bus-width strap and a three-state strap. They then stay fixed until the next reset.

After reset, software may set a single enable bit. When the bit is set, the pins become outputs and carry two byte-lane parity bits and an error/enable flag. The parity bits are even parity over each byte of the 16-bit data bus. They are captured, together with the flag, whenever the data-valid strobe is high, whatever the direction of the bus cycle. Clearing the enable bit returns the pins to inputs and leaves the latched straps alone.

Top module: `strap_parity_pins`

## Requirements
- R1: While `rst` is high, `pin_oe` and `pin_out` are all zero and the three strap outputs are zero.
- R2: `pin_oe` is either 3'b000 or 3'b111; it is 3'b111 exactly when the enable bit is set.
- R3: On the first rising edge with `rst` low, the straps take the pin levels as they were two edges earlier: `strap_cpu_off` from `pin_in[0]`, `strap_wide_bus` from `pin_in[1]`, `strap_tristate` from `pin_in[2]`. The new values are visible after that edge.
- R4: After the capture, the straps do not follow `pin_in` until the next reset.
- R5: A write to the enable bit (`reg_wr` high) while `rst` is high has no effect; the bit reads as zero after reset.
- R6: With `rst` low, `reg_wr` high loads `reg_wdata` into the enable bit at the next edge. Its value is seen on `pin_oe`.
- R7: Clearing the enable bit does not change the strap outputs.
- R8: On an edge where `data_valid` is high, the parity bits are loaded with the XOR of `data[7:0]` (pin 0) and of `data[15:8]` (pin 1). They hold between strobes.
- R9: On an edge where `data_valid` is high, pin 2's output value is loaded from `perr_flag`.
- R10: While the enable bit is zero, `pin_out` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| pin_in | input | 3 | Levels seen on the three shared pins |
| pin_out | output | 3 | Values driven onto the pins when enabled |
| pin_oe | output | 3 | Output enable per pin |
| reg_wr | input | 1 | Write strobe for the enable bit |
| reg_wdata | input | 1 | New value of the enable bit |
| data | input | 16 | Data bus, two byte lanes |
| data_valid | input | 1 | Data bus strobe; loads parity and flag |
| perr_flag | input | 1 | Error/enable indication sent out on pin 2 |
| strap_cpu_off | output | 1 | Latched CPU-off strap |
| strap_wide_bus | output | 1 | Latched bus-width strap |
| strap_tristate | output | 1 | Latched three-state strap |

## Verification
Two pairs of events can land on the same edge. The first pair is an enable write and a data-valid strobe. The second pair is the strap capture edge and a write that arrives right after reset. The bench drives both pairs on the same edge: it sets the enable bit in the cycle where the strap capture happens, and it clears the enable bit in the cycle of a parity strobe. A behavioural reference model runs alongside the design and is compared with the pins and straps on every falling edge. That comparison shows that the parity captured on the shared edge appears only while the pins are enabled, and that the straps remain unchanged.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int PIN_COUNT = 3;

    // Packed order sets the bit positions: member listed last is bit 0.
    typedef struct packed {
        logic tristate_sel;   // pin 2
        logic wide_bus;       // pin 1
        logic cpu_off;        // pin 0
    } strap_t;

    typedef struct packed {
        logic err_flag;       // pin 2
        logic par_hi;         // pin 1
        logic par_lo;         // pin 0
    } pin_drive_t;

    // Even parity bit of an arbitrary lane: makes the total count of ones even.
    function automatic logic lane_even_parity(input logic [63:0] lane, input int width);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (i < width) acc = acc ^ lane[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/strap_sampler.sv
module strap_sampler #(
    parameter int W           = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] strap_q
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [W-1:0] sync_q [SYNC_STAGES];
    logic         taken_q;

    // Synchronizer runs through reset so it holds the pin levels at release.
    always_ff @(posedge clk) begin
        sync_q[0] <= pin_in;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            sync_q[i] <= sync_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= '0;
            taken_q <= 1'b0;
        end else if (!taken_q) begin
            strap_q <= sync_q[LAST];
            taken_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pin_enable_reg.sv
module pin_enable_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wdata,
    output logic en_q
);
    // Reset has priority, so writes made during reset are lost.
    always_ff @(posedge clk) begin
        if (rst)     en_q <= 1'b0;
        else if (wr) en_q <= wdata;
    end
endmodule

// File: rtl/lane_parity.sv
module lane_parity
    import strap_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES*LANE_W-1:0] data,
    input  logic                    data_valid,
    input  logic                    flag_in,
    output logic [LANES-1:0]        par_q,
    output logic                    flag_q
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [63:0] lane_ext;
        assign lane_ext = 64'(data[l*LANE_W +: LANE_W]);
        always_ff @(posedge clk) begin
            if (rst)             par_q[l] <= 1'b0;
            else if (data_valid) par_q[l] <= lane_even_parity(lane_ext, LANE_W);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             flag_q <= 1'b0;
        else if (data_valid) flag_q <= flag_in;
    end
endmodule

// File: rtl/strap_parity_pins.sv
module strap_parity_pins
    import strap_pkg::*;
#(
    parameter int LANE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PIN_COUNT-1:0]  pin_in,
    output logic [PIN_COUNT-1:0]  pin_out,
    output logic [PIN_COUNT-1:0]  pin_oe,
    input  logic                  reg_wr,
    input  logic                  reg_wdata,
    input  logic [2*LANE_W-1:0]   data,
    input  logic                  data_valid,
    input  logic                  perr_flag,
    output logic                  strap_cpu_off,
    output logic                  strap_wide_bus,
    output logic                  strap_tristate
);
    localparam int LANES = PIN_COUNT - 1;

    strap_t     straps;
    pin_drive_t drive;
    logic       en_q;
    logic [LANES-1:0] par_q;
    logic       flag_q;

    strap_sampler #(.W(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst(rst), .pin_in(pin_in), .strap_q(straps)
    );

    pin_enable_reg u_enable (
        .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata), .en_q(en_q)
    );

    lane_parity #(.LANE_W(LANE_W), .LANES(LANES)) u_parity (
        .clk(clk), .rst(rst), .data(data), .data_valid(data_valid),
        .flag_in(perr_flag), .par_q(par_q), .flag_q(flag_q)
    );

    always_comb begin
        drive.par_lo   = par_q[0];
        drive.par_hi   = par_q[1];
        drive.err_flag = flag_q;
    end

    assign pin_oe         = {PIN_COUNT{en_q}};
    assign pin_out        = en_q ? drive : '0;
    assign strap_cpu_off  = straps.cpu_off;
    assign strap_wide_bus = straps.wide_bus;
    assign strap_tristate = straps.tristate_sel;
endmodule

// File: rtl/strap_parity_pins_chk.sv
module strap_parity_pins_chk #(
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [2:0]          pin_out,
    input logic [2:0]          pin_oe,
    input logic                reg_wr,
    input logic                reg_wdata,
    input logic [2*LANE_W-1:0] data,
    input logic                data_valid,
    input logic                perr_flag,
    input logic                strap_cpu_off,
    input logic                strap_wide_bus,
    input logic                strap_tristate
);
    logic [1:0] since_rst;
    logic       rst_prev;

    always_ff @(posedge clk) begin
        rst_prev <= rst;
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    always @(negedge clk) begin
        if (rst_prev === 1'b1 && rst === 1'b1) begin
            assert_reset_quiet_R1: assert (pin_oe == 3'b000 && pin_out == 3'b000 &&
                !strap_cpu_off && !strap_wide_bus && !strap_tristate);
        end
    end

    assert_oe_uniform_R2: assert property (@(posedge clk) disable iff (rst)
        (pin_oe == 3'b000) || (pin_oe == 3'b111));

    assert_straps_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> $stable({strap_tristate, strap_wide_bus, strap_cpu_off}));

    assert_enable_write_R6: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (pin_oe == {3{$past(reg_wdata)}}));

    assert_lane_parity_R8: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> (pin_oe == 3'b000) ||
            (pin_out[0] == ^$past(data[LANE_W-1:0]) &&
             pin_out[1] == ^$past(data[2*LANE_W-1:LANE_W])));

    assert_flag_pin_R9: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> (pin_oe == 3'b000) || (pin_out[2] == $past(perr_flag)));

    assert_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
        (pin_oe == 3'b000) |-> (pin_out == 3'b000));
endmodule

bind strap_parity_pins strap_parity_pins_chk #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/strap_parity_pins_bench.sv
`timescale 1ns/1ps
module strap_parity_pins_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  pin_in = 3'b000;
    logic [2:0]  pin_out, pin_oe;
    logic        reg_wr = 1'b0, reg_wdata = 1'b0;
    logic [15:0] data = 16'h0;
    logic        data_valid = 1'b0, perr_flag = 1'b0;
    logic        strap_cpu_off, strap_wide_bus, strap_tristate;

    int checks = 0, fails = 0;
    string phase = "R1";
    bit done = 0;

    always #5 clk = ~clk;

    strap_parity_pins u_strap_parity_pins (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .data(data), .data_valid(data_valid),
        .perr_flag(perr_flag), .strap_cpu_off(strap_cpu_off),
        .strap_wide_bus(strap_wide_bus), .strap_tristate(strap_tristate)
    );

    // Behavioural reference model.
    bit       m_en, m_p0, m_p1, m_err, m_taken;
    bit [2:0] m_strap, m_h1, m_h2;

    function automatic bit odd_count(input bit [7:0] b);
        int n = 0;
        for (int i = 0; i < 8; i++) n += b[i];
        return (n % 2) == 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_p0 = 0; m_p1 = 0; m_err = 0; m_taken = 0; m_strap = 0;
        end else begin
            if (reg_wr) m_en = reg_wdata;
            if (data_valid) begin
                m_p0 = odd_count(data[7:0]);
                m_p1 = odd_count(data[15:8]);
                m_err = perr_flag;
            end
            if (!m_taken) begin m_strap = m_h2; m_taken = 1; end
        end
        m_h2 = m_h1;
        m_h1 = pin_in;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Full comparison with the model on every cycle.
    always @(negedge clk) begin
        if (!done) begin
            check(phase, "pin_oe", pin_oe, m_en ? 3'b111 : 3'b000);
            check(phase, "pin_out", pin_out, m_en ? {m_err, m_p1, m_p0} : 3'b000);
            check(phase, "straps", {strap_tristate, strap_wide_bus, strap_cpu_off}, m_strap);
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [15:0] d, input logic f);
        data = d; perr_flag = f; data_valid = 1'b1;
        step(1);
        data_valid = 1'b0;
    endtask

    initial begin
        #2000000;
        fails++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1, R5: pins held as straps, write attempted inside reset.
        pin_in = 3'b101; reg_wr = 1'b1; reg_wdata = 1'b1;
        step(5);
        check("R1", "oe in reset", pin_oe, 0);
        check("R1", "straps in reset", {strap_tristate, strap_wide_bus, strap_cpu_off}, 0);
        reg_wr = 1'b0; rst = 1'b0; phase = "R3";
        step(1);
        check("R3", "straps after release", {strap_tristate, strap_wide_bus, strap_cpu_off}, 3'b101);
        check("R5", "enable after reset write", pin_oe, 0);
        // R4: pins move, straps must not.
        phase = "R4"; pin_in = 3'b010;
        step(4);
        check("R4", "straps hold", {strap_tristate, strap_wide_bus, strap_cpu_off}, 3'b101);
        // R10: strobe while disabled keeps outputs low.
        phase = "R10";
        strobe(16'h0103, 1'b1);
        check("R10", "disabled out", pin_out, 0);
        // R6: enable; captured parity from before becomes visible.
        phase = "R6"; reg_wr = 1'b1; reg_wdata = 1'b1;
        step(1); reg_wr = 1'b0;
        check("R6", "oe set", pin_oe, 3'b111);
        check("R8", "held parity", pin_out, 3'b110);
        // R8, R9: several data patterns.
        phase = "R8";
        strobe(16'hFF7F, 1'b0);
        check("R8", "ff7f", pin_out, 3'b001);
        strobe(16'h0000, 1'b1);
        check("R9", "flag", pin_out, 3'b100);
        strobe(16'h8001, 1'b0);
        check("R8", "8001", pin_out, 3'b011);
        step(3);
        check("R8", "hold between strobes", pin_out, 3'b011);
        // Same edge: clear enable and strobe.
        phase = "R7"; reg_wr = 1'b1; reg_wdata = 1'b0;
        strobe(16'h0100, 1'b1);
        reg_wr = 1'b0;
        check("R10", "cleared out", pin_out, 0);
        check("R7", "straps after clear", {strap_tristate, strap_wide_bus, strap_cpu_off}, 3'b101);
        reg_wr = 1'b1; reg_wdata = 1'b1; step(1); reg_wr = 1'b0;
        check("R8", "parity from shared edge", pin_out, 3'b110);
        // Second reset with new strap levels; write lands on capture edge.
        phase = "R3"; rst = 1'b1; pin_in = 3'b011;
        step(4);
        rst = 1'b0; reg_wr = 1'b1; reg_wdata = 1'b1;
        step(1); reg_wr = 1'b0;
        check("R3", "second capture", {strap_tristate, strap_wide_bus, strap_cpu_off}, 3'b011);
        check("R6", "write on capture edge", pin_oe, 3'b111);
        check("R2", "oe uniform", pin_oe, 3'b111);
        step(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule